// File: doc/BRIEF.md
# Halfword Negative Multiply-Accumulate Unit

This block is the execution datapath for a multiply-subtract instruction. Each accepted operation picks one 16-bit halfword from each of two 32-bit sources, multiplies the two halfwords as signed numbers, and subtracts the 32-bit product from a 32-bit accumulator operand. The difference is formed one bit wider than the data path. The result is then either wrapped to 32 bits or, in saturating mode, clamped to the nearest 32-bit signed limit.

Alongside the result the unit reports an overflow bit and keeps a sticky summary-overflow bit that only an explicit clear lowers. When recording is requested, it also emits a four-bit condition field describing the sign of the result. All outputs are registered with one cycle of latency, and a valid bit travels with the data. Every width is derived from one `DATA_W` parameter. A second parameter selects how the multiplier is built.

Top module: `nmac_unit`

## Requirements
- R1: With `hi_sel`=0 the operands are the low halves `src_a[HALF_W-1:0]` and `src_b[HALF_W-1:0]`, which are bits 16..31 in most-significant-first numbering. With `hi_sel`=1 they are the upper halves `src_a[DATA_W-1:HALF_W]` and `src_b[DATA_W-1:HALF_W]`. The unselected halves have no effect on any output.
- R2: The two selected halfwords are multiplied as two's-complement values. With `sat_en`=0, `result` equals `acc - product` reduced modulo 2^DATA_W.
- R3: `ovf` is 1 exactly when `acc - product`, taken as a signed integer, lies outside [-2^(DATA_W-1), 2^(DATA_W-1)-1]. This holds in both modes.
- R4: With `sat_en`=1, an overflowing positive difference gives 0x7FF..F and an overflowing negative difference gives 0x800..0. A difference that does not overflow gives the same value as modulo mode.
- R5: `out_valid` equals `in_valid` from the previous clock edge. `result`, `ovf` and `cr_flags` change only on edges where `in_valid`=1 and otherwise hold.
- R6: `so` is set on an edge where `in_valid`=1 and the operation overflows. It is cleared on an edge where `so_clr`=1. When both happen on the same edge, the overflow wins and `so` stays 1.
- R7: When `in_valid`=1 and `rec_en`=1, `cr_flags` loads {negative, positive, zero, so}: bit 3 is result < 0, bit 2 is result > 0, bit 1 is result == 0, and bit 0 is the updated `so`. When `in_valid`=1 and `rec_en`=0, `cr_flags` loads 4'b0000.
- R8: While `rst` is high (synchronous, active high), `out_valid`, `result`, `ovf`, `so` and `cr_flags` are all zero after the next edge.
- R9: `DATA_W` must be even and at least 4. `MULT_ARCH` 0 (operator) and 1 (partial-product array) give bit-identical outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this edge |
| hi_sel | input | 1 | 1 selects upper halfwords, 0 lower |
| sat_en | input | 1 | 1 selects saturating arithmetic |
| rec_en | input | 1 | 1 produces condition flags |
| so_clr | input | 1 | Clears the sticky summary-overflow bit |
| src_a | input | DATA_W | First source operand |
| src_b | input | DATA_W | Second source operand |
| acc | input | DATA_W | Accumulator operand |
| out_valid | output | 1 | Result registers hold a new operation |
| result | output | DATA_W | Wrapped or clamped difference |
| ovf | output | 1 | Overflow of the last operation |
| so | output | 1 | Sticky summary overflow |
| cr_flags | output | 4 | {neg, pos, zero, so} condition field |

## Verification
The bench builds two copies with `DATA_W`=8, so the halfwords are 4 bits wide: one copy uses the partial-product multiplier and the other uses the operator form. At this width every pair of signed halfwords (all 256 pairs) can be swept in both halfword positions and both arithmetic modes. The sweep is run against accumulators placed at both saturation limits, near zero, and mid-range. This reaches overflow in each direction, the largest product (-8 × -8), zero results, and a sticky clear that coincides with a new overflow. Comparing the two copies on every operation covers the multiplier variant choice.

// File: rtl/nmac_pkg.sv
package nmac_pkg;

   localparam int MUL_ARCH_OPERATOR = 0;
   localparam int MUL_ARCH_ARRAY    = 1;

   // condition field, most significant first
   typedef struct packed {
      logic neg;
      logic pos;
      logic zero;
      logic so;
   } nmac_cr_t;

endpackage

// File: rtl/nmac_half_sel.sv
module nmac_half_sel #(
   parameter int DATA_W = 32,
   parameter int HALF_W = DATA_W / 2
) (
   input  logic              hi_sel,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic [HALF_W-1:0] half_a,
   output logic [HALF_W-1:0] half_b
);

   always_comb begin
      if (hi_sel) begin
         half_a = src_a[DATA_W-1:HALF_W];
         half_b = src_b[DATA_W-1:HALF_W];
      end else begin
         half_a = src_a[HALF_W-1:0];
         half_b = src_b[HALF_W-1:0];
      end
   end

endmodule

// File: rtl/nmac_mult.sv
module nmac_mult #(
   parameter int HALF_W    = 16,
   parameter int MULT_ARCH = 1,
   localparam int PROD_W   = 2 * HALF_W
) (
   input  logic [HALF_W-1:0] half_a,
   input  logic [HALF_W-1:0] half_b,
   output logic [PROD_W-1:0] prod
);

   logic [PROD_W-1:0] ext_a;
   logic [PROD_W-1:0] ext_b;

   assign ext_a = {{HALF_W{half_a[HALF_W-1]}}, half_a};
   assign ext_b = {{HALF_W{half_b[HALF_W-1]}}, half_b};

   generate
      if (MULT_ARCH == nmac_pkg::MUL_ARCH_OPERATOR) begin : g_operator
         // low PROD_W bits of the product of sign-extended operands
         assign prod = ext_a * ext_b;
      end else begin : g_array
         logic [PROD_W-1:0] part [HALF_W];
         for (genvar i = 0; i < HALF_W; i++) begin : g_part
            assign part[i] = half_b[i] ? (ext_a << i) : '0;
         end
         always_comb begin
            logic [PROD_W-1:0] sum;
            sum = '0;
            for (int k = 0; k < HALF_W - 1; k++) begin
               sum = sum + part[k];
            end
            // the top bit of a signed multiplier has negative weight
            prod = sum - part[HALF_W-1];
         end
      end
   endgenerate

endmodule

// File: rtl/nmac_sub_sat.sv
module nmac_sub_sat #(
   parameter int DATA_W = 32
) (
   input  logic              sat_en,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] prod,
   output logic [DATA_W-1:0] res,
   output logic              ovf
);

   localparam logic [DATA_W-1:0] POS_LIMIT = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] NEG_LIMIT = {1'b1, {(DATA_W-1){1'b0}}};

   logic [DATA_W:0] wide;

   assign wide = {acc[DATA_W-1], acc} - {prod[DATA_W-1], prod};
   assign ovf  = wide[DATA_W] ^ wide[DATA_W-1];

   always_comb begin
      if (sat_en && ovf) begin
         res = wide[DATA_W] ? NEG_LIMIT : POS_LIMIT;
      end else begin
         res = wide[DATA_W-1:0];
      end
   end

endmodule

// File: rtl/nmac_unit.sv
module nmac_unit
   import nmac_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MULT_ARCH = MUL_ARCH_ARRAY
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              hi_sel,
   input  logic              sat_en,
   input  logic              rec_en,
   input  logic              so_clr,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [DATA_W-1:0] acc,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              ovf,
   output logic              so,
   output logic [3:0]        cr_flags
);

   localparam int HALF_W = DATA_W / 2;

   // R9 elaboration-time parameter checks
   generate
      if ((DATA_W % 2) != 0 || DATA_W < 4) begin : g_bad_width
         $error("nmac_unit: DATA_W must be even and at least 4");
      end
      if (MULT_ARCH != MUL_ARCH_OPERATOR && MULT_ARCH != MUL_ARCH_ARRAY) begin : g_bad_arch
         $error("nmac_unit: MULT_ARCH must be 0 or 1");
      end
   endgenerate

   logic [HALF_W-1:0] half_a;
   logic [HALF_W-1:0] half_b;
   logic [DATA_W-1:0] prod;
   logic [DATA_W-1:0] res_c;
   logic              ovf_c;
   logic              so_next;
   nmac_cr_t          cr_next;
   nmac_cr_t          cr_q;
   logic [DATA_W-1:0] result_q;
   logic              ovf_q;
   logic              so_q;
   logic              valid_q;

   nmac_half_sel #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_sel (
      .hi_sel (hi_sel),
      .src_a  (src_a),
      .src_b  (src_b),
      .half_a (half_a),
      .half_b (half_b)
   );

   nmac_mult #(.HALF_W(HALF_W), .MULT_ARCH(MULT_ARCH)) u_mult (
      .half_a (half_a),
      .half_b (half_b),
      .prod   (prod)
   );

   nmac_sub_sat #(.DATA_W(DATA_W)) u_sub (
      .sat_en (sat_en),
      .acc    (acc),
      .prod   (prod),
      .res    (res_c),
      .ovf    (ovf_c)
   );

   // a fresh overflow outranks a clear on the same edge
   assign so_next = (so_q & ~so_clr) | (in_valid & ovf_c);

   always_comb begin
      cr_next = '0;
      if (rec_en) begin
         cr_next.neg  = res_c[DATA_W-1];
         cr_next.zero = (res_c == '0);
         cr_next.pos  = ~res_c[DATA_W-1] & (res_c != '0);
         cr_next.so   = so_next;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q  <= 1'b0;
         result_q <= '0;
         ovf_q    <= 1'b0;
         so_q     <= 1'b0;
         cr_q     <= '0;
      end else begin
         valid_q <= in_valid;
         so_q    <= so_next;
         if (in_valid) begin
            result_q <= res_c;
            ovf_q    <= ovf_c;
            cr_q     <= cr_next;
         end
      end
   end

   assign out_valid = valid_q;
   assign result    = result_q;
   assign ovf       = ovf_q;
   assign so        = so_q;
   assign cr_flags  = cr_q;

endmodule

// File: rtl/nmac_chk.sv
module nmac_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              sat_en,
   input logic              rec_en,
   input logic              so_clr,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              ovf,
   input logic              so,
   input logic [3:0]        cr_flags
);

   localparam logic [DATA_W-1:0] POS_LIMIT = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] NEG_LIMIT = {1'b1, {(DATA_W-1){1'b0}}};

   // R5
   valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R5
   valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R5
   hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(result) && $stable(ovf) && $stable(cr_flags)));

   // R4
   sat_clamp_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && sat_en) |=> (!ovf || result == POS_LIMIT || result == NEG_LIMIT));

   // R6
   so_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (so && !so_clr) |=> so);

   // R6
   so_from_ovf_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && ovf) |-> so);

   // R6
   so_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (so_clr && !in_valid) |=> !so);

   // R7
   cr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && rec_en) |=> ($countones(cr_flags[3:1]) == 1 && cr_flags[0] == so));

   // R7
   cr_off_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !rec_en) |=> (cr_flags == 4'b0000));

   // R8
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && !so && !ovf && result == '0 && cr_flags == 4'b0000));

endmodule

bind nmac_unit nmac_chk #(.DATA_W(DATA_W)) u_nmac_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .sat_en    (sat_en),
   .rec_en    (rec_en),
   .so_clr    (so_clr),
   .out_valid (out_valid),
   .result    (result),
   .ovf       (ovf),
   .so        (so),
   .cr_flags  (cr_flags)
);

// File: tb/tb_nmac_unit.sv
module tb_nmac_unit;

   localparam int DW = 8;
   localparam int HW = DW / 2;

   logic          clk = 1'b0;
   logic          rst;
   logic          in_valid, hi_sel, sat_en, rec_en, so_clr;
   logic [DW-1:0] src_a, src_b, acc;
   logic          out_valid, ovf, so;
   logic [DW-1:0] result;
   logic [3:0]    cr_flags;
   logic          out_valid_b, ovf_b, so_b;
   logic [DW-1:0] result_b;
   logic [3:0]    cr_flags_b;

   int checks   = 0;
   int failures = 0;
   logic so_model = 1'b0;

   always #5 clk = ~clk;

   nmac_unit #(.DATA_W(DW), .MULT_ARCH(1)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .hi_sel(hi_sel),
      .sat_en(sat_en), .rec_en(rec_en), .so_clr(so_clr),
      .src_a(src_a), .src_b(src_b), .acc(acc),
      .out_valid(out_valid), .result(result), .ovf(ovf), .so(so),
      .cr_flags(cr_flags)
   );

   nmac_unit #(.DATA_W(DW), .MULT_ARCH(0)) dut_op (
      .clk(clk), .rst(rst), .in_valid(in_valid), .hi_sel(hi_sel),
      .sat_en(sat_en), .rec_en(rec_en), .so_clr(so_clr),
      .src_a(src_a), .src_b(src_b), .acc(acc),
      .out_valid(out_valid_b), .result(result_b), .ovf(ovf_b), .so(so_b),
      .cr_flags(cr_flags_b)
   );

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, actual, expected, $time);
      end
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   // one operation: inputs at a falling edge, outputs checked at the next one
   task automatic run_op(input bit hi, input int ha, input int hb, input int accv,
                         input bit sat, input bit rec, input bit clr);
      logic [HW-1:0] junk_a, junk_b;
      int diff, exp_res, exp_neg;
      bit exp_ovf;
      logic [DW-1:0] res8;
      logic [3:0] exp_cr;
      junk_a   = HW'(ha * 5 + 3);
      junk_b   = HW'(hb * 7 + 1);
      in_valid = 1'b1;
      hi_sel   = hi;
      sat_en   = sat;
      rec_en   = rec;
      so_clr   = clr;
      src_a    = hi ? {HW'(ha), junk_a} : {junk_a, HW'(ha)};
      src_b    = hi ? {HW'(hb), junk_b} : {junk_b, HW'(hb)};
      acc      = DW'(accv);
      diff     = accv - ha * hb;
      exp_ovf  = (diff > 127) || (diff < -128);
      if (sat && exp_ovf) exp_res = (diff > 0) ? 127 : -128;
      else                exp_res = diff;
      res8     = DW'(exp_res);
      so_model = (so_model & ~clr) | exp_ovf;
      exp_neg  = $signed(res8) < 0;
      exp_cr   = rec ? {exp_neg != 0, $signed(res8) > 0, res8 == 0, so_model} : 4'b0000;
      @(negedge clk);
      in_valid = 1'b0;
      so_clr   = 1'b0;
      check("R5 out_valid", int'(out_valid), 1);
      if (sat) check("R4/R1 result sat", int'(result), int'(res8));
      else     check("R2/R1 result modulo", int'(result), int'(res8));
      check("R3 ovf", int'(ovf), int'(exp_ovf));
      check("R6 so", int'(so), int'(so_model));
      check("R7 cr_flags", int'(cr_flags), int'(exp_cr));
      check("R9 arch agree", int'({result_b, ovf_b, so_b, cr_flags_b}),
            int'({result, ovf, so, cr_flags}));
   endtask

   initial begin
      #(200000 * 10);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      int accs [8] = '{0, 127, -128, 1, -1, 100, -100, 37};
      logic [DW-1:0] held;
      rst = 1'b1; in_valid = 1'b0; hi_sel = 1'b0; sat_en = 1'b0;
      rec_en = 1'b0; so_clr = 1'b0; src_a = '0; src_b = '0; acc = '0;
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8 out_valid", int'(out_valid), 0);
      check("R8 result", int'(result), 0);
      check("R8 so", int'(so), 0);
      check("R8 cr_flags", int'({ovf, cr_flags}), 0);
      rst = 1'b0;
      @(negedge clk);

      // R1..R7, R9 exhaustive halfword sweep
      for (int hi = 0; hi < 2; hi++)
         for (int s = 0; s < 2; s++)
            for (int ai = 0; ai < 8; ai++)
               for (int ia = -8; ia < 8; ia++)
                  for (int ib = -8; ib < 8; ib++)
                     run_op(hi[0], ia, ib, accs[ai], s[0], ib[0] ^ ia[1],
                            (ia == 7) && (ib == 7));

      // R6 clear coinciding with overflow: -128 - 7*7 overflows
      run_op(1'b0, 7, 7, -128, 1'b0, 1'b1, 1'b1);
      check("R6 overflow beats clear", int'(so), 1);

      // R5 idle cycle with different inputs holds outputs
      held = result;
      src_a = 8'h5A; src_b = 8'hC3; acc = 8'h11; rec_en = 1'b0;
      @(negedge clk);
      check("R5 idle out_valid", int'(out_valid), 0);
      check("R5 idle hold result", int'(result), int'(held));

      // R6 clear without an operation
      so_clr = 1'b1;
      @(negedge clk);
      so_clr = 1'b0;
      so_model = 1'b0;
      check("R6 cleared so", int'(so), 0);
      check("R5 clear holds result", int'(result), int'(held));

      // R8 reset mid-run
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R8 reset again", int'({out_valid, result, ovf, so, cr_flags}), 0);

      summary();
      $finish;
   end

endmodule